// File: doc/BRIEF.md
# Initiator Standby and Target Idle Handshake Controller

This block sequences the low-power handshakes of a processing module that owns both a bus initiator port (used to move data) and a register target port (used for configuration). Software selects, at run time, one of four policies for the initiator's standby behaviour and one of four policies for the target's idle behaviour. Under the smart policies, a software standby request is combined with the engine's busy signal before standby is raised toward the power manager. The power manager's idle request is then acknowledged only once standby already holds.

A read-only completion bit in the control register reports that the module is fully awake. That means standby is released, no idle request is pending and no idle acknowledge is outstanding. A permit output gates initiator traffic on that bit. A self-clearing soft-reset bit returns every piece of state to its default for a fixed number of cycles. The clock gating that follows a finished handshake belongs to the power manager, not to this block.

Top module: `pm_hs_ctrl`

## Requirements
- R1: After the asynchronous reset, the configuration register reads 0x28 (both mode fields at 2), the control register reads 0x00, and stby_req, idle_ack and traffic_ok are 0. From the second cycle after reset release, the control register reads 0x40 while the module stays awake.
- R2: A configuration write (wr_sel=0) with bit 0 set starts a soft reset. Bit 0 then reads 1 for exactly 4 cycles and clears by itself. During those cycles the mode fields read their defaults, control bit 5 reads 0, stby_req and traffic_ok are 0, and all register writes are ignored.
- R3: After a soft reset ends, the configuration register reads 0x28 and control bit 5 reads 0, whatever was programmed before.
- R4: Standby mode sits in configuration bits 5:4 (0 force, 1 never, 2 smart, 3 smart with wakeup). In force mode, stby_req is 1 from the cycle after the mode takes effect, regardless of busy or control bit 5.
- R5: In never-standby mode, stby_req stays 0 even with control bit 5 set and the engine idle.
- R6: In the two smart standby modes, stby_req equals (control bit 5 AND NOT engine_busy), registered one cycle.
- R7: A control write (wr_sel=1) sets the software standby request from data bit 5 and clears it when that bit is 0. The request reads back in control bit 5.
- R8: Idle mode sits in configuration bits 3:2 with the same encoding. In force-idle mode, idle_ack follows idle_req one cycle later, whatever the standby or busy state.
- R9: In no-idle mode, idle_ack stays 0 whatever idle_req does.
- R10: In the smart idle modes, idle_ack equals (idle_req AND stby_req AND NOT engine_busy), registered one cycle. An idle request that arrives without standby is therefore not acknowledged.
- R11: Control bit 6 (read-only) reads 1 one cycle after stby_req, idle_ack and idle_req were all 0, and reads 0 otherwise.
- R12: traffic_ok is 1 only while control bit 6 reads 1, stby_req is 0 and no soft reset is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 configuration, 1 control |
| wr_data | input | 8 | Write data |
| rd_cfg | output | 8 | Configuration register readback |
| rd_ctl | output | 8 | Control register readback |
| engine_busy | input | 1 | Processing engine still needs the initiator |
| idle_req | input | 1 | Idle request from the power manager |
| stby_req | output | 1 | Standby request to the power manager |
| idle_ack | output | 1 | Idle acknowledge to the power manager |
| traffic_ok | output | 1 | Initiator traffic permitted |

## Verification
Several corner cases are targeted directly.

- Soft reset is counted cycle by cycle. A counter off by one would show bit 0 high for three or five cycles. A write slipping through during the reset would leave the software standby bit set afterwards.
- An idle request is raised while standby is low under smart idle. A design that skipped the ordering would acknowledge early.
- The same request is raised under force idle, where a design that wrongly gated on standby would stay silent.
- Busy is raised while acknowledged. This checks that standby and acknowledge both drop in the next cycle.
- The completion bit and traffic permit are watched as the handshake unwinds. A design that raised the permit too soon would allow traffic while idle was still acknowledged.

// File: rtl/pm_hs_pkg.sv
package pm_hs_pkg;
  typedef enum logic [1:0] {
    PM_FORCE    = 2'd0,
    PM_NEVER    = 2'd1,
    PM_SMART    = 2'd2,
    PM_SMART_WK = 2'd3
  } pm_mode_e;

  localparam int CFG_SRST_BIT = 0;
  localparam int CFG_IDLE_LO  = 2;
  localparam int CFG_STBY_LO  = 4;
  localparam int CTL_SWSB_BIT = 5;
  localparam int CTL_DONE_BIT = 6;

  function automatic logic is_smart(pm_mode_e m);
    return (m == PM_SMART) || (m == PM_SMART_WK);
  endfunction
endpackage

// File: rtl/pm_regs.sv
module pm_regs
  import pm_hs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SRST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hs_done,
  output pm_mode_e          stby_mode,
  output pm_mode_e          idle_mode,
  output logic              sw_stby,
  output logic              srst_busy,
  output logic              state_clr,
  output logic [DATA_W-1:0] rd_cfg,
  output logic [DATA_W-1:0] rd_ctl
);
  localparam int CNT_W = (SRST_CYCLES > 1) ? $clog2(SRST_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SRST_CYCLES - 1);

  pm_mode_e         stby_mode_d, idle_mode_d;
  logic             sw_stby_d, srst_busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cfg_we, ctl_we, srst_start;
  logic             unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[DATA_W-1:CTL_SWSB_BIT+1], wr_data[1]};

  assign cfg_we     = wr_en && !wr_sel && !srst_busy;
  assign ctl_we     = wr_en &&  wr_sel && !srst_busy;
  assign srst_start = cfg_we && wr_data[CFG_SRST_BIT];
  assign state_clr  = srst_start || srst_busy;

  always_comb begin
    stby_mode_d = stby_mode;
    idle_mode_d = idle_mode;
    sw_stby_d   = sw_stby;
    srst_busy_d = srst_busy;
    cnt_d       = cnt_q;
    if (srst_start) begin
      stby_mode_d = PM_SMART;
      idle_mode_d = PM_SMART;
      sw_stby_d   = 1'b0;
      srst_busy_d = 1'b1;
      cnt_d       = CNT_LOAD;
    end else if (srst_busy) begin
      if (cnt_q == '0) srst_busy_d = 1'b0;
      else             cnt_d       = cnt_q - 1'b1;
    end else begin
      if (cfg_we) begin
        stby_mode_d = pm_mode_e'(wr_data[CFG_STBY_LO +: 2]);
        idle_mode_d = pm_mode_e'(wr_data[CFG_IDLE_LO +: 2]);
      end
      if (ctl_we) sw_stby_d = wr_data[CTL_SWSB_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stby_mode <= PM_SMART;
      idle_mode <= PM_SMART;
      sw_stby   <= 1'b0;
      srst_busy <= 1'b0;
      cnt_q     <= '0;
    end else begin
      stby_mode <= stby_mode_d;
      idle_mode <= idle_mode_d;
      sw_stby   <= sw_stby_d;
      srst_busy <= srst_busy_d;
      cnt_q     <= cnt_d;
    end
  end

  always_comb begin
    rd_cfg = '0;
    rd_cfg[CFG_SRST_BIT]      = srst_busy;
    rd_cfg[CFG_IDLE_LO +: 2]  = idle_mode;
    rd_cfg[CFG_STBY_LO +: 2]  = stby_mode;
    rd_ctl = '0;
    rd_ctl[CTL_SWSB_BIT]      = sw_stby;
    rd_ctl[CTL_DONE_BIT]      = hs_done;
  end

  // R2: registers sit at defaults for the whole soft reset
  assert_srst_defaults_R2: assert property (@(posedge clk) disable iff (!rst_n)
    srst_busy |-> (stby_mode == PM_SMART && idle_mode == PM_SMART && !sw_stby));
  // R2: the last count ends the reset on the next edge
  assert_srst_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_busy && cnt_q == '0) |=> !srst_busy);
endmodule

// File: rtl/pm_stby.sv
module pm_stby
  import pm_hs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  pm_mode_e mode,
  input  logic     sw_stby,
  input  logic     busy,
  output logic     stby_q
);
  logic stby_d;

  always_comb begin
    stby_d = 1'b0;
    if (!clr) begin
      case (mode)
        PM_FORCE:    stby_d = 1'b1;
        PM_NEVER:    stby_d = 1'b0;
        default:     stby_d = sw_stby && !busy;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stby_q <= 1'b0;
    else        stby_q <= stby_d;
  end

  // R4: force mode puts the initiator in standby on the next edge
  assert_force_stby_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_FORCE && !clr) |=> stby_q);
  // R5: never-standby mode never raises the request
  assert_never_stby_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_NEVER) |=> !stby_q);
endmodule

// File: rtl/pm_idle.sv
module pm_idle
  import pm_hs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  pm_mode_e mode,
  input  logic     idle_req,
  input  logic     stby_q,
  input  logic     busy,
  output logic     ack_q,
  output logic     done_q
);
  logic ack_d, done_d;

  always_comb begin
    ack_d = 1'b0;
    if (!clr) begin
      case (mode)
        PM_FORCE: ack_d = idle_req;
        PM_NEVER: ack_d = 1'b0;
        default:  ack_d = idle_req && stby_q && !busy;
      endcase
    end
    done_d = !clr && !stby_q && !ack_q && !idle_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ack_q  <= ack_d;
      done_q <= done_d;
    end
  end

  // R9: no-idle mode never acknowledges
  assert_idle_never_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_NEVER) |=> !ack_q);
  // R10: under smart idle, acknowledge only rises once standby was already up
  assert_smart_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ack_q) && is_smart($past(mode))) |-> $past(stby_q));
endmodule

// File: rtl/pm_hs_ctrl.sv
module pm_hs_ctrl
  import pm_hs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SRST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_cfg,
  output logic [DATA_W-1:0] rd_ctl,
  input  logic              engine_busy,
  input  logic              idle_req,
  output logic              stby_req,
  output logic              idle_ack,
  output logic              traffic_ok
);
  pm_mode_e stby_mode, idle_mode;
  logic     sw_stby, srst_busy, state_clr, hs_done;

  pm_regs #(.DATA_W(DATA_W), .SRST_CYCLES(SRST_CYCLES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .hs_done(hs_done), .stby_mode(stby_mode), .idle_mode(idle_mode),
    .sw_stby(sw_stby), .srst_busy(srst_busy), .state_clr(state_clr),
    .rd_cfg(rd_cfg), .rd_ctl(rd_ctl)
  );

  pm_stby u_stby (
    .clk(clk), .rst_n(rst_n), .clr(state_clr), .mode(stby_mode),
    .sw_stby(sw_stby), .busy(engine_busy), .stby_q(stby_req)
  );

  pm_idle u_idle (
    .clk(clk), .rst_n(rst_n), .clr(state_clr), .mode(idle_mode),
    .idle_req(idle_req), .stby_q(stby_req), .busy(engine_busy),
    .ack_q(idle_ack), .done_q(hs_done)
  );

  assign traffic_ok = hs_done && !stby_req && !srst_busy;

  // R12: traffic is never permitted while idle is acknowledged
  assert_no_traffic_in_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    traffic_ok |-> !idle_ack);
endmodule

// File: tb/sim_pm_hs_ctrl.sv
module sim_pm_hs_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_cfg, rd_ctl;
  logic       engine_busy = 1'b0, idle_req = 1'b0;
  logic       stby_req, idle_ack, traffic_ok;
  int         n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  pm_hs_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_cfg(rd_cfg), .rd_ctl(rd_ctl), .engine_busy(engine_busy),
    .idle_req(idle_req), .stby_req(stby_req), .idle_ack(idle_ack),
    .traffic_ok(traffic_ok)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // drive at a falling edge; returns at the falling edge after the write edge
  task automatic wr(logic sel, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    step(1);
    rst_n = 1'b1;
    #1;
    chk("R1 cfg", rd_cfg, 8'h28);
    chk("R1 ctl", rd_ctl, 8'h00);
    chk("R1 stby", stby_req, 0);
    chk("R1 ack", idle_ack, 0);
    chk("R1 traffic", traffic_ok, 0);
    step(2);
    chk("R1 ctl awake", rd_ctl, 8'h40);
    chk("R12 traffic awake", traffic_ok, 1);
  endtask

  task automatic t_smart;
    wr(1'b1, 8'h20);
    chk("R7 ctl bit5 set", rd_ctl[5], 1);
    chk("R6 stby not yet", stby_req, 0);
    step(1);
    chk("R6 stby up", stby_req, 1);
    chk("R12 traffic off in stby", traffic_ok, 0);
    step(1);
    chk("R11 done low in stby", rd_ctl, 8'h20);
    engine_busy = 1'b1;
    step(1);
    chk("R6 busy drops stby", stby_req, 0);
    engine_busy = 1'b0;
    step(1);
    chk("R6 stby back", stby_req, 1);
    idle_req = 1'b1;
    step(1);
    chk("R10 ack after stby", idle_ack, 1);
    chk("R12 no traffic in idle", traffic_ok, 0);
    engine_busy = 1'b1;
    step(1);
    chk("R10 busy drops ack", idle_ack, 0);
    chk("R6 busy drops stby again", stby_req, 0);
    engine_busy = 1'b0; idle_req = 1'b0;
    wr(1'b1, 8'h00);
    chk("R7 ctl bit5 clear", rd_ctl[5], 0);
    step(2);
    chk("R11 done back", rd_ctl, 8'h40);
    chk("R12 traffic back", traffic_ok, 1);
    idle_req = 1'b1;
    step(2);
    chk("R10 no ack without stby", idle_ack, 0);
    chk("R11 done low on pending req", rd_ctl[6], 0);
    chk("R12 traffic low on pending req", traffic_ok, 0);
    idle_req = 1'b0;
    step(2);
  endtask

  task automatic t_force_stby;
    engine_busy = 1'b1;
    wr(1'b0, 8'h08);
    chk("R4 cfg readback", rd_cfg, 8'h08);
    step(1);
    chk("R4 force stby", stby_req, 1);
    chk("R12 traffic off", traffic_ok, 0);
    engine_busy = 1'b0;
  endtask

  task automatic t_never_stby;
    wr(1'b0, 8'h18);
    wr(1'b1, 8'h20);
    step(2);
    chk("R5 never stby", stby_req, 0);
    chk("R7 R11 ctl", rd_ctl, 8'h60);
    chk("R12 traffic", traffic_ok, 1);
  endtask

  task automatic t_idle_force;
    wr(1'b0, 8'h10);
    engine_busy = 1'b1; idle_req = 1'b1;
    step(1);
    chk("R8 force ack", idle_ack, 1);
    chk("R8 stby still low", stby_req, 0);
    idle_req = 1'b0;
    step(1);
    chk("R8 ack follows drop", idle_ack, 0);
    engine_busy = 1'b0;
  endtask

  task automatic t_idle_never;
    wr(1'b0, 8'h04);
    idle_req = 1'b1;
    step(2);
    chk("R9 stby forced", stby_req, 1);
    chk("R9 no ack", idle_ack, 0);
    idle_req = 1'b0;
  endtask

  task automatic t_soft_reset;
    wr(1'b0, 8'h14);
    wr(1'b1, 8'h20);
    wr(1'b0, 8'h3D);
    for (int i = 0; i < 4; i++) begin
      chk("R2 srst bit high", rd_cfg, 8'h29);
      chk("R2 ctl cleared", rd_ctl[5], 0);
      chk("R2 no traffic", traffic_ok, 0);
      chk("R2 no stby", stby_req, 0);
      if (i == 1) begin
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'h20;
      end else begin
        wr_en = 1'b0;
      end
      step(1);
    end
    chk("R2 srst bit cleared", rd_cfg[0], 0);
    chk("R3 cfg default", rd_cfg, 8'h28);
    chk("R3 write ignored", rd_ctl[5], 0);
    step(1);
    chk("R12 traffic after srst", traffic_ok, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_smart();
    t_force_stby();
    t_never_stby();
    t_idle_force();
    t_idle_never();
    t_soft_reset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule